// File: doc/BRIEF.md
# Host Adapter Register Port

This block is the adapter-side model of a byte-wide host register port for a storage host adapter. A host driver reaches it through three I/O offsets. Offsets 0 and 1 each have a write meaning and a separate read meaning. The block takes a command opcode followed by a fixed number of parameter bytes. It hands reply bytes back one at a time. It reports completion or rejection through a status byte and an interrupt byte, and it models the hard, soft, interrupt and bus reset actions of the control register.

A small opcode table sets the parameter and reply byte counts for each command. Reply contents come from configuration inputs. When a mailbox-setup command completes, the block presents the decoded mailbox count and base address on plain outputs with a one-cycle valid pulse. The start-mailbox opcode produces a one-cycle pulse.

The bus access pins are plain register strobes with no back-pressure. Pacing is done in software through the busy and data-in-ready status bits. A write to the command offset while busy is set is dropped. A read of the data-in offset with no reply pending returns zero and changes nothing.

Top module: `hbp_host_port`

## Requirements
- R1: After power-on reset or a control write with bit 7 set (hard reset), status reads 0x80 (diagnostic active) for exactly SETTLE_CYCLES cycles. It then reads exactly 0x30 (initialisation required 0x20 plus ready 0x10), and the interrupt byte reads 0x00.
- R2: Offset 0 reads status and offset 1 reads the data-in byte. Offset 2 reads the interrupt byte, and offset 3 reads 0x00. A write to offset 2 has no effect on status or interrupt.
- R3: An opcode outside {0x01, 0x02, 0x04, 0x0B, 0x81} sets status bit 0 (command invalid) and interrupt 0x84 (complete 0x04 plus valid 0x80), and ready stays high.
- R4: A control write with bit 5 set clears the interrupt byte and the command-invalid bit.
- R5: Every accepted byte on offset 1 sets status bit 3 (busy) for BUSY_CYCLES cycles. A write to offset 1 while busy is ignored.
- R6: Opcode 0x04 drops ready and returns four bytes of cfg_inquiry, least significant byte first. Status bit 2 (data-in ready) is set while bytes remain, and each read of offset 1 pops one byte. Interrupt 0x84 is raised when the last byte is read.
- R7: Opcode 0x0B returns three bytes of cfg_setup, least significant byte first, and follows the same handshake as R6.
- R8: Opcode 0x01 takes four parameters: the count, then a 24-bit base with the most significant byte first. After the last parameter, mbox_count and mbox_base are presented with mbox_ext=0 and a one-cycle mbox_init_valid pulse. Interrupt 0x84 is raised and the initialisation-required bit clears.
- R9: Opcode 0x81 takes five parameters: the count, then a 32-bit base with the least significant byte first. Completion is as in R8, with mbox_ext=1.
- R10: Opcode 0x02 pulses mbox_start for one cycle and raises no interrupt. It is accepted in idle and also while a reply is pending, when ready is low. Any other byte written while a reply is pending is ignored.
- R11: A control write with bit 4 set pulses scsi_bus_reset for one cycle and sets interrupt 0x88 (bus reset state 0x08 plus valid 0x80).
- R12: A control write with bit 6 set (soft reset) aborts a command in progress and clears the interrupt byte and busy. It returns to ready without a settle period and leaves the initialisation-required bit unchanged.
- R13: The irq output equals bit 7 of the interrupt byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops data-in at offset 1) |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected offset |
| irq | output | 1 | Interrupt request |
| cfg_inquiry | input | 32 | Reply contents for opcode 0x04 |
| cfg_setup | input | 24 | Reply contents for opcode 0x0B |
| mbox_init_valid | output | 1 | One-cycle pulse on mailbox setup completion |
| mbox_count | output | 8 | Decoded mailbox count |
| mbox_base | output | 32 | Decoded mailbox base address |
| mbox_ext | output | 1 | Base came from the 32-bit setup command |
| mbox_start | output | 1 | One-cycle pulse on start-mailbox opcode |
| scsi_bus_reset | output | 1 | One-cycle pulse on bus reset request |

## Verification
The hardest situations to reach are a write landing while busy is still set, and the start opcode arriving in the middle of a pending reply. The stimulus reaches both by issuing back-to-back writes with no status poll between them. For the start opcode, it interleaves the write between data-in pops, then checks that the remaining reply bytes still arrive in order. A sweep over all 256 opcode values confirms the table classification from the status and interrupt bytes alone.

// File: rtl/hbp_pkg.sv
package hbp_pkg;

  localparam logic [7:0] OP_MBOX_INIT     = 8'h01;
  localparam logic [7:0] OP_MBOX_START    = 8'h02;
  localparam logic [7:0] OP_INQUIRY       = 8'h04;
  localparam logic [7:0] OP_SETUP         = 8'h0B;
  localparam logic [7:0] OP_MBOX_INIT_EXT = 8'h81;

  localparam int CTL_BUS_RST = 4;
  localparam int CTL_INT_RST = 5;
  localparam int CTL_SOFT    = 6;
  localparam int CTL_HARD    = 7;

  localparam logic [1:0] OFS_CTL_STAT = 2'd0;
  localparam logic [1:0] OFS_CMD_DATA = 2'd1;
  localparam logic [1:0] OFS_INTR     = 2'd2;

  localparam int PARAM_MAX = 5;
  localparam int REPLY_MAX = 4;
  localparam int CNT_W     = $clog2(PARAM_MAX + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_PARAM, PH_REPLY} phase_t;

  typedef struct packed {
    logic             known;
    logic             silent;
    logic [CNT_W-1:0] nparm;
    logic [CNT_W-1:0] nreply;
    logic             use_setup;
  } op_info_t;

endpackage

// File: rtl/hbp_down_timer.sv
module hbp_down_timer #(
  parameter int unsigned LEN = 4,
  parameter bit START_LOADED = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic clear,
  output logic active
);
  localparam int W = (LEN < 1) ? 1 : $clog2(LEN + 1);
  localparam logic [W-1:0] LEN_V = W'(LEN);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= START_LOADED ? LEN_V : '0;
    else if (clear)          cnt_q <= '0;
    else if (load)           cnt_q <= LEN_V;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign active = (cnt_q != '0);
endmodule

// File: rtl/hbp_cmd_table.sv
module hbp_cmd_table
  import hbp_pkg::*;
(
  input  logic [7:0] opcode,
  output op_info_t   info
);
  always_comb begin
    info = '0;
    case (opcode)
      OP_MBOX_INIT: begin
        info.known = 1'b1;
        info.nparm = CNT_W'(4);
      end
      OP_MBOX_START: begin
        info.known  = 1'b1;
        info.silent = 1'b1;
      end
      OP_INQUIRY: begin
        info.known  = 1'b1;
        info.nreply = CNT_W'(4);
      end
      OP_SETUP: begin
        info.known     = 1'b1;
        info.nreply    = CNT_W'(3);
        info.use_setup = 1'b1;
      end
      OP_MBOX_INIT_EXT: begin
        info.known = 1'b1;
        info.nparm = CNT_W'(5);
      end
      default: info = '0;
    endcase
  end
endmodule

// File: rtl/hbp_reply_mux.sv
module hbp_reply_mux
  import hbp_pkg::*;
(
  input  logic [31:0]      inquiry,
  input  logic [23:0]      setup,
  input  logic             use_setup,
  input  logic [CNT_W-1:0] idx,
  output logic [7:0]       byte_out
);
  logic [7:0] inq_b [REPLY_MAX];
  logic [7:0] set_b [REPLY_MAX];

  for (genvar g = 0; g < REPLY_MAX; g++) begin : g_bytes
    assign inq_b[g] = inquiry[8*g +: 8];
    if (g < 3) begin : g_set
      assign set_b[g] = setup[8*g +: 8];
    end else begin : g_pad
      assign set_b[g] = 8'h00;
    end
  end

  always_comb begin
    if (idx >= CNT_W'(REPLY_MAX)) byte_out = 8'h00;
    else if (use_setup)           byte_out = set_b[idx[1:0]];
    else                          byte_out = inq_b[idx[1:0]];
  end
endmodule

// File: rtl/hbp_host_port.sv
module hbp_host_port
  import hbp_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 16,
  parameter int unsigned BUSY_CYCLES   = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [1:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic        irq,
  input  logic [31:0] cfg_inquiry,
  input  logic [23:0] cfg_setup,
  output logic        mbox_init_valid,
  output logic [7:0]  mbox_count,
  output logic [31:0] mbox_base,
  output logic        mbox_ext,
  output logic        mbox_start,
  output logic        scsi_bus_reset
);
  phase_t           state_q;
  op_info_t         op_info;
  logic [7:0]       op_q;
  logic [CNT_W-1:0] pidx_q, ridx_q, nparm_q, nreply_q;
  logic             use_setup_q;
  logic [7:0]       parm_q [PARAM_MAX];
  logic [7:0]       parm_n [PARAM_MAX];
  logic [7:0]       intr_q, intr_n, stat_byte, reply_byte;
  logic             cmdinv_q, initreq_q;
  logic             start_q, busrst_q, initv_q;
  logic             settling, busy;

  logic wr_ctl, wr_cmd, rd_dat;
  logic hard_rst, soft_rst, int_rst, bus_rst;
  logic ready, byte_take, take_op, take_parm, start_hit;
  logic set_inv, last_parm, pop, last_read, set_cc;

  always_comb begin
    wr_ctl    = bus_wr && (bus_addr == OFS_CTL_STAT);
    wr_cmd    = bus_wr && (bus_addr == OFS_CMD_DATA);
    rd_dat    = bus_rd && (bus_addr == OFS_CMD_DATA);
    hard_rst  = wr_ctl && bus_wdata[CTL_HARD];
    soft_rst  = wr_ctl && !bus_wdata[CTL_HARD] && bus_wdata[CTL_SOFT];
    int_rst   = wr_ctl && !bus_wdata[CTL_HARD] && bus_wdata[CTL_INT_RST];
    bus_rst   = wr_ctl && !bus_wdata[CTL_HARD] && bus_wdata[CTL_BUS_RST];
    ready     = !settling && (state_q == PH_IDLE);
    byte_take = wr_cmd && !settling && !busy &&
                ((state_q != PH_REPLY) || (bus_wdata == OP_MBOX_START));
    take_op   = byte_take && (state_q == PH_IDLE);
    take_parm = byte_take && (state_q == PH_PARAM);
    start_hit = byte_take && (state_q != PH_PARAM) && (bus_wdata == OP_MBOX_START);
    set_inv   = take_op && !op_info.known;
    last_parm = take_parm && (pidx_q == nparm_q - 1'b1);
    pop       = rd_dat && (state_q == PH_REPLY) && !hard_rst && !soft_rst;
    last_read = pop && (ridx_q == nreply_q - 1'b1);
    set_cc    = set_inv || last_parm || last_read;
  end

  always_comb begin
    intr_n = intr_q;
    if (hard_rst || soft_rst || int_rst) intr_n = 8'h00;
    if (set_cc)  intr_n[2] = 1'b1;
    if (bus_rst) intr_n[3] = 1'b1;
    intr_n[6:4] = 3'b000;
    intr_n[7]   = |intr_n[3:0];
  end

  always_comb begin
    for (int i = 0; i < PARAM_MAX; i++) parm_n[i] = parm_q[i];
    if (take_parm) parm_n[pidx_q] = bus_wdata;
  end

  hbp_cmd_table u_table (
    .opcode (bus_wdata),
    .info   (op_info)
  );

  hbp_down_timer #(.LEN(SETTLE_CYCLES), .START_LOADED(1'b1)) u_settle (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (hard_rst),
    .clear  (1'b0),
    .active (settling)
  );

  hbp_down_timer #(.LEN(BUSY_CYCLES), .START_LOADED(1'b0)) u_busy (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (byte_take),
    .clear  (hard_rst || soft_rst),
    .active (busy)
  );

  hbp_reply_mux u_reply (
    .inquiry   (cfg_inquiry),
    .setup     (cfg_setup),
    .use_setup (use_setup_q),
    .idx       (ridx_q),
    .byte_out  (reply_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= PH_IDLE;
      intr_q      <= 8'h00;
      cmdinv_q    <= 1'b0;
      initreq_q   <= 1'b1;
      op_q        <= 8'h00;
      pidx_q      <= '0;
      ridx_q      <= '0;
      nparm_q     <= '0;
      nreply_q    <= '0;
      use_setup_q <= 1'b0;
    end else if (hard_rst) begin
      state_q     <= PH_IDLE;
      intr_q      <= 8'h00;
      cmdinv_q    <= 1'b0;
      initreq_q   <= 1'b1;
      pidx_q      <= '0;
      ridx_q      <= '0;
    end else begin
      intr_q <= intr_n;
      if (soft_rst || int_rst) cmdinv_q <= 1'b0;
      else if (set_inv)        cmdinv_q <= 1'b1;
      if (last_parm) initreq_q <= 1'b0;
      if (soft_rst) begin
        state_q <= PH_IDLE;
      end else begin
        if (take_op && op_info.known && !op_info.silent) begin
          op_q <= bus_wdata;
          if (op_info.nparm != '0) begin
            state_q <= PH_PARAM;
            pidx_q  <= '0;
            nparm_q <= op_info.nparm;
          end else if (op_info.nreply != '0) begin
            state_q     <= PH_REPLY;
            ridx_q      <= '0;
            nreply_q    <= op_info.nreply;
            use_setup_q <= op_info.use_setup;
          end
        end
        if (take_parm) begin
          if (last_parm) state_q <= PH_IDLE;
          else           pidx_q  <= pidx_q + 1'b1;
        end
        if (pop) begin
          if (last_read) state_q <= PH_IDLE;
          else           ridx_q  <= ridx_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PARAM_MAX; i++) parm_q[i] <= 8'h00;
      mbox_count <= 8'h00;
      mbox_base  <= 32'h0;
      mbox_ext   <= 1'b0;
      start_q    <= 1'b0;
      busrst_q   <= 1'b0;
      initv_q    <= 1'b0;
    end else begin
      for (int i = 0; i < PARAM_MAX; i++) parm_q[i] <= parm_n[i];
      start_q  <= start_hit;
      busrst_q <= bus_rst;
      initv_q  <= last_parm;
      if (last_parm) begin
        mbox_count <= parm_n[0];
        if (op_q == OP_MBOX_INIT_EXT) begin
          mbox_base <= {parm_n[4], parm_n[3], parm_n[2], parm_n[1]};
          mbox_ext  <= 1'b1;
        end else begin
          mbox_base <= {8'h00, parm_n[1], parm_n[2], parm_n[3]};
          mbox_ext  <= 1'b0;
        end
      end
    end
  end

  assign stat_byte = {settling, 1'b0, initreq_q && !settling, ready, busy,
                      (state_q == PH_REPLY) && !settling, 1'b0, cmdinv_q && !settling};

  always_comb begin
    case (bus_addr)
      OFS_CTL_STAT: bus_rdata = stat_byte;
      OFS_CMD_DATA: bus_rdata = (state_q == PH_REPLY) ? reply_byte : 8'h00;
      OFS_INTR:     bus_rdata = intr_q;
      default:      bus_rdata = 8'h00;
    endcase
  end

  assign irq             = intr_q[7];
  assign mbox_start      = start_q;
  assign scsi_bus_reset  = busrst_q;
  assign mbox_init_valid = initv_q;
endmodule

// File: rtl/hbp_host_port_chk.sv
module hbp_host_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [1:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic [7:0] status,
  input logic [7:0] intr,
  input logic       mbox_start
);
  a_r1_hard_reset_diag: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0 && bus_wdata[7]) |=> (status == 8'h80));

  a_r6_dirrdy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    status[2] |-> !status[4]);

  a_r3_inv_with_complete: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[0]) |-> intr[2]);

  a_r4_int_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0 && bus_wdata == 8'h20 && !bus_rd) |=> (intr == 8'h00));

  a_r10_start_silent: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intr[2]) |-> !mbox_start);

  a_r12_soft_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0 && bus_wdata[6] && !bus_wdata[7]) |=> (status[4] != status[7]));
endmodule

bind hbp_host_port hbp_host_port_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .status     (stat_byte),
  .intr       (intr_q),
  .mbox_start (mbox_start)
);

// File: tb/hbp_host_port_test.sv
`timescale 1ns/1ps
module hbp_host_port_test;
  localparam int SETTLE = 6;
  localparam int BUSYC  = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic        irq;
  logic [31:0] cfg_inquiry = 32'h0;
  logic [23:0] cfg_setup = 24'h0;
  logic        mbox_init_valid, mbox_ext, mbox_start, scsi_bus_reset;
  logic [7:0]  mbox_count;
  logic [31:0] mbox_base;

  int checks = 0;
  int errors = 0;
  bit exp_init = 1'b1;

  always #2.5 clk = ~clk;

  hbp_host_port #(.SETTLE_CYCLES(SETTLE), .BUSY_CYCLES(BUSYC)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .cfg_inquiry(cfg_inquiry), .cfg_setup(cfg_setup),
    .mbox_init_valid(mbox_init_valid), .mbox_count(mbox_count),
    .mbox_base(mbox_base), .mbox_ext(mbox_ext), .mbox_start(mbox_start),
    .scsi_bus_reset(scsi_bus_reset)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // Tasks start and end at a falling edge.
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 40; i++) begin
      rd(2'd0, s);
      if (!s[3] && !s[7]) break;
    end
  endtask

  function automatic logic [7:0] idle_stat();
    return 8'h10 | (exp_init ? 8'h20 : 8'h00);
  endfunction

  task automatic count_settle(input string req);
    logic [7:0] s;
    int n = 0;
    for (int i = 0; i < 100; i++) begin
      rd(2'd0, s);
      if (s == 8'h80) n++;
      else break;
    end
    chk({req, " settle length"}, n, SETTLE);
    chk({req, " settled status"}, s, 8'h30);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] s, v;
    logic [7:0] b [5];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 power-on settle
    count_settle("R1");
    rd(2'd2, s); chk("R1 intr after reset", s, 8'h00);

    // R2 offsets
    wr(2'd2, 8'hFF);
    rd(2'd2, s); chk("R2 intr write ignored", s, 8'h00);
    rd(2'd0, s); chk("R2 status after intr write", s, 8'h30);
    rd(2'd3, s); chk("R2 offset3 reads zero", s, 8'h00);
    rd(2'd1, s); chk("R2 data-in empty reads zero", s, 8'h00);

    // Opcode sweep: R3, R5, R10, R12
    for (int op = 0; op < 256; op++) begin
      logic [7:0] es, ei;
      bit known;
      known = (op == 8'h01) || (op == 8'h02) || (op == 8'h04) || (op == 8'h0B) || (op == 8'h81);
      wr(2'd1, 8'(op));
      chk("R10 start pulse only for 0x02", mbox_start, (op == 8'h02));
      rd(2'd0, s); chk("R5 busy after opcode", s[3], 1'b1);
      wait_idle();
      if (!known)                         begin es = 8'h31; ei = 8'h84; end
      else if (op == 8'h02)               begin es = 8'h30; ei = 8'h00; end
      else if (op == 8'h04 || op == 8'h0B) begin es = 8'h24; ei = 8'h00; end
      else                                begin es = 8'h20; ei = 8'h00; end
      rd(2'd0, s); chk("R3 status after opcode", s, es);
      rd(2'd2, s); chk("R3 intr after opcode", s, ei);
      chk("R13 irq follows valid", irq, ei[7]);
      wr(2'd0, 8'h60);
      rd(2'd0, s); chk("R12 soft reset status", s, 8'h30);
      rd(2'd2, s); chk("R4 intr cleared", s, 8'h00);
    end

    // R4: interrupt reset clears command invalid
    wr(2'd1, 8'h77); wait_idle();
    wr(2'd0, 8'h20);
    rd(2'd0, s); chk("R4 cmd invalid cleared", s, 8'h30);
    rd(2'd2, s); chk("R4 intr cleared", s, 8'h00);

    // R8 / R5: 24-bit setup with a write dropped while busy
    for (int p = 0; p < 6; p++) begin
      for (int k = 0; k < 5; k++) b[k] = 8'(p * 53 + k * 29 + 7);
      wr(2'd1, 8'h01);
      if (p == 0) wr(2'd1, 8'hAA);
      wait_idle();
      for (int k = 0; k < 4; k++) begin
        wr(2'd1, b[k]);
        if (k == 3) chk("R8 init valid pulse", mbox_init_valid, 1'b1);
        wait_idle();
      end
      exp_init = 1'b0;
      chk("R5 R8 count", mbox_count, b[0]);
      chk("R8 base msb first", mbox_base, {8'h00, b[1], b[2], b[3]});
      chk("R8 ext flag", mbox_ext, 1'b0);
      rd(2'd2, s); chk("R8 complete intr", s, 8'h84);
      rd(2'd0, s); chk("R8 status ready, init cleared", s, 8'h10);
      wr(2'd0, 8'h20);
    end

    // R9: 32-bit setup
    for (int p = 0; p < 6; p++) begin
      for (int k = 0; k < 5; k++) b[k] = 8'(p * 71 + k * 13 + 3);
      wr(2'd1, 8'h81); wait_idle();
      for (int k = 0; k < 5; k++) begin
        wr(2'd1, b[k]);
        if (k == 4) chk("R9 init valid pulse", mbox_init_valid, 1'b1);
        wait_idle();
      end
      chk("R9 count", mbox_count, b[0]);
      chk("R9 base lsb first", mbox_base, {b[4], b[3], b[2], b[1]});
      chk("R9 ext flag", mbox_ext, 1'b1);
      rd(2'd2, s); chk("R9 complete intr", s, 8'h84);
      wr(2'd0, 8'h20);
    end

    // R6 / R7: replies
    for (int p = 0; p < 4; p++) begin
      cfg_inquiry = 32'(p * 32'h1357_9BDF + 32'h0246_8ACE);
      cfg_setup   = 24'(p * 24'h2468AC + 24'h13579B);
      wr(2'd1, 8'h04); wait_idle();
      for (int k = 0; k < 4; k++) begin
        rd(2'd0, s); chk("R6 data-in ready", s, 8'h04);
        if (k == 1 && p == 0) begin
          wr(2'd1, 8'h02);
          chk("R10 start during reply", mbox_start, 1'b1);
          wait_idle();
          wr(2'd1, 8'h55);
          wait_idle();
          rd(2'd2, s); chk("R10 no intr from start", s, 8'h00);
        end
        rd(2'd1, v); chk("R6 inquiry byte", v, cfg_inquiry[8*k +: 8]);
      end
      rd(2'd0, s); chk("R6 ready after reply", s, idle_stat());
      rd(2'd2, s); chk("R6 complete intr", s, 8'h84);
      chk("R13 irq high", irq, 1'b1);
      wr(2'd0, 8'h20);
      chk("R13 irq low", irq, 1'b0);

      wr(2'd1, 8'h0B); wait_idle();
      for (int k = 0; k < 3; k++) begin
        rd(2'd0, s); chk("R7 data-in ready", s, 8'h04);
        rd(2'd1, v); chk("R7 setup byte", v, cfg_setup[8*k +: 8]);
      end
      rd(2'd0, s); chk("R7 ready after reply", s, idle_stat());
      rd(2'd2, s); chk("R7 complete intr", s, 8'h84);
      wr(2'd0, 8'h20);
    end

    // R11 bus reset
    wr(2'd0, 8'h10);
    chk("R11 bus reset pulse", scsi_bus_reset, 1'b1);
    rd(2'd2, s); chk("R11 intr", s, 8'h88);
    rd(2'd0, s); chk("R11 status unchanged", s, idle_stat());
    wr(2'd0, 8'h20);
    rd(2'd2, s); chk("R4 clear after bus reset", s, 8'h00);

    // R12 soft reset mid-parameters
    wr(2'd1, 8'h81); wait_idle();
    wr(2'd1, 8'h12);
    wr(2'd0, 8'h40);
    rd(2'd0, s); chk("R12 abort status", s, idle_stat());
    rd(2'd2, s); chk("R12 abort intr", s, 8'h00);
    wr(2'd1, 8'h0B); wait_idle();
    rd(2'd1, v); chk("R12 next command works", v, cfg_setup[7:0]);
    wr(2'd0, 8'h40);

    // R1 hard reset
    wr(2'd0, 8'h80);
    exp_init = 1'b1;
    count_settle("R1 hard");
    rd(2'd2, s); chk("R1 intr after hard reset", s, 8'h00);

    finish_run();
  end
endmodule